// File: doc/BRIEF.md
# Serial Link Health Event Monitor

This block sits beside a two-core serial receiver, its transceiver PLL and a memory controller. It watches their status pins and turns them into health registers that software can read. Each status input is asynchronous to the monitor clock. Every one of them passes through a two-flop synchroniser before the block uses it for edge detection, counting or live reporting.

Software reads through a simple port. It drives a read strobe and an address, and the data comes back one cycle later. The port returns three kinds of value:

- live bits: link-up per core, PLL lock, and an all-lanes-clean summary;
- sixteen per-lane error counters;
- three event counters: receiver resync, PLL loss-of-lock and memory reset.

Every counter is 16 bits wide and saturates at its maximum. A read returns the counter's value and then clears it. An event that lands in the same cycle as that read is not lost: the counter restarts at 1.

Address map (5-bit address, 32-bit data):

| Address | Contents |
|---|---|
| 0x00 | Status word, live, not cleared by a read |
| 0x01 | Resync counter |
| 0x02 | PLL word |
| 0x03 | Memory reset counter |
| 0x10 + n | Error counter of lane n, for n = 0..15. Lanes 0..7 belong to core 0 and lanes 8..15 to core 1 |

Any other address reads as zero.

Top module: `link_health_mon`

## Requirements
- R1: Status word bit c (c = 0, 1) is 1 exactly while core c has both its SYSREF-captured flag and its sync flag high after synchronisation. Reading the status word does not change it.
- R2: Each of the 16 lanes has its own error counter, read at address 0x10 + lane. The counter adds one for every clock cycle in which that lane's error input is high.
- R3: The resync counter (address 0x01) adds one on each rising edge of the AND of both cores' sync flags. Toggling one core's sync while the other core's sync is low adds nothing.
- R4: The PLL word (address 0x02) carries the live lock flag in bit 16 and the loss-of-lock count in bits 15:0. Each falling edge of the lock flag is one loss event, and a lock drop lasting a single cycle is still counted.
- R5: The memory reset counter (address 0x03) adds one on each falling edge of the memory user-logic reset input.
- R6: Reading a counter returns its current value and clears it. Reading the status word or the PLL word leaves the live bits unchanged. After reset, the status word reads 0x8 and every counter reads 0.
- R7: If a counting event reaches a counter in the same cycle as a clearing read of that counter, the read returns the old value and the counter becomes 1.
- R8: Counters saturate at 65535 and do not wrap.
- R9: Status word bit 3 is 1 exactly when all 16 lane error counters are zero. Bit 2 of the status word is the live lock flag.
- R10: A change on any status input reaches the counters and the live bits two clock cycles after it is sampled. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sysref_seen_i | input | 2 | Per-core SYSREF-captured flag (asynchronous) |
| link_sync_i | input | 2 | Per-core link sync flag (asynchronous) |
| lane_err_i | input | 16 | Per-lane error pulse; bit n is lane n (asynchronous) |
| pll_lock_i | input | 1 | Transceiver PLL lock flag (asynchronous) |
| mem_rst_i | input | 1 | Memory controller user-logic reset (asynchronous) |
| rd_en_i | input | 1 | Read strobe; a read of a counter clears it |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 32 | Read data, registered, valid the cycle after rd_en_i |

## Verification
The hardest case to reach from the ports is an event arriving at a counter in exactly the cycle its clearing read takes effect. The event has to be launched at the input so that its two synchroniser stages end on the same clock edge as the read.

The bench produces this case directly. It raises one lane error for a single cycle, then issues the read two cycles after the error was driven. It then checks that the read returned the old value and that the next read returns 1.

Saturation needs more than 65535 error cycles on one lane, so the bench holds one lane's error input high for that long. Random sparse lane errors and random lock drops, including single-cycle drops, are counted in the bench and compared lane by lane.

// File: rtl/link_health_pkg.sv
package link_health_pkg;
  localparam int ADR_STATUS = 0;
  localparam int ADR_RESYNC = 1;
  localparam int ADR_PLL    = 2;
  localparam int ADR_MEMRST = 3;
  localparam int ADR_LANE0  = 16;
endpackage

// File: rtl/lh_bit_sync.sv
module lh_bit_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/lh_event_counter.sv
module lh_event_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX_V = {W{1'b1}};
  localparam logic [W-1:0] ONE_V = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = inc_i | clr_i;
    if (clr_i) begin
      cnt_d = inc_i ? ONE_V : '0;
    end else if (inc_i && (cnt_q != MAX_V)) begin
      cnt_d = cnt_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX_V && inc_i && !clr_i) |=> (cnt_q == MAX_V));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !inc_i) |=> (cnt_q == '0));
  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && inc_i) |=> (cnt_q == ONE_V));
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && inc_i && cnt_q != MAX_V) |=> (cnt_q == $past(cnt_q) + ONE_V));
endmodule

// File: rtl/link_health_mon.sv
module link_health_mon
  import link_health_pkg::*;
#(
  parameter int NUM_CORES      = 2,
  parameter int LANES_PER_CORE = 8,
  parameter int CNT_W          = 16,
  parameter int ADDR_W         = 5,
  parameter int DATA_W         = 32
) (
  input  logic                               clk,
  input  logic                               rst_ni,
  input  logic [NUM_CORES-1:0]               sysref_seen_i,
  input  logic [NUM_CORES-1:0]               link_sync_i,
  input  logic [NUM_CORES*LANES_PER_CORE-1:0] lane_err_i,
  input  logic                               pll_lock_i,
  input  logic                               mem_rst_i,
  input  logic                               rd_en_i,
  input  logic [ADDR_W-1:0]                  rd_addr_i,
  output logic [DATA_W-1:0]                  rd_data_o
);
  localparam int NUM_LANES = NUM_CORES * LANES_PER_CORE;
  localparam int IN_W      = 2 * NUM_CORES + NUM_LANES + 2;
  localparam int STAT_W    = NUM_CORES + 2;
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  // all status inputs through one synchroniser bank
  logic [IN_W-1:0]      raw_in;
  logic [IN_W-1:0]      syn_in;
  logic [NUM_CORES-1:0] sysref_s;
  logic [NUM_CORES-1:0] sync_s;
  logic [NUM_LANES-1:0] lane_err_s;
  logic                 lock_s;
  logic                 memrst_s;

  assign raw_in = {mem_rst_i, pll_lock_i, lane_err_i, link_sync_i, sysref_seen_i};

  lh_bit_sync #(.W(IN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign {memrst_s, lock_s, lane_err_s, sync_s, sysref_s} = syn_in;

  // edge detection
  logic sync_all_s;
  logic sync_all_q;
  logic lock_q;
  logic memrst_q;
  logic resync_ev;
  logic lockloss_ev;
  logic memrst_ev;

  assign sync_all_s = &sync_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_all_q <= 1'b0;
      lock_q     <= 1'b0;
      memrst_q   <= 1'b0;
    end else begin
      sync_all_q <= sync_all_s;
      lock_q     <= lock_s;
      memrst_q   <= memrst_s;
    end
  end

  assign resync_ev   = sync_all_s & ~sync_all_q;
  assign lockloss_ev = ~lock_s & lock_q;
  assign memrst_ev   = ~memrst_s & memrst_q;

  // read decode into clear strobes
  logic                 clr_resync;
  logic                 clr_pll;
  logic                 clr_mem;
  logic [NUM_LANES-1:0] clr_lane;

  assign clr_resync = rd_en_i && (rd_addr_i == ADDR_W'(ADR_RESYNC));
  assign clr_pll    = rd_en_i && (rd_addr_i == ADDR_W'(ADR_PLL));
  assign clr_mem    = rd_en_i && (rd_addr_i == ADDR_W'(ADR_MEMRST));

  // counters
  logic [CNT_W-1:0] resync_cnt;
  logic [CNT_W-1:0] pll_cnt;
  logic [CNT_W-1:0] mem_cnt;
  logic [CNT_W-1:0] lane_cnt [NUM_LANES];

  lh_event_counter #(.W(CNT_W)) u_resync_cnt (
    .clk (clk), .rst_n (rst_n), .inc_i (resync_ev), .clr_i (clr_resync), .cnt_o (resync_cnt)
  );
  lh_event_counter #(.W(CNT_W)) u_pll_cnt (
    .clk (clk), .rst_n (rst_n), .inc_i (lockloss_ev), .clr_i (clr_pll), .cnt_o (pll_cnt)
  );
  lh_event_counter #(.W(CNT_W)) u_mem_cnt (
    .clk (clk), .rst_n (rst_n), .inc_i (memrst_ev), .clr_i (clr_mem), .cnt_o (mem_cnt)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign clr_lane[g] = rd_en_i && (rd_addr_i == ADDR_W'(ADR_LANE0 + g));
    lh_event_counter #(.W(CNT_W)) u_lane_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (lane_err_s[g]),
      .clr_i (clr_lane[g]),
      .cnt_o (lane_cnt[g])
    );
  end

  // live status word
  logic                 lanes_clean;
  logic [NUM_CORES-1:0] link_up;
  logic [STAT_W-1:0]    status_w;

  always_comb begin
    lanes_clean = 1'b1;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (lane_cnt[i] != '0) lanes_clean = 1'b0;
    end
  end

  assign link_up  = sysref_s & sync_s;
  assign status_w = {lanes_clean, lock_s, link_up};

  // read mux and output register
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    rd_d = '0;
    if (rd_addr_i == ADDR_W'(ADR_STATUS)) begin
      rd_d[STAT_W-1:0] = status_w;
    end else if (rd_addr_i == ADDR_W'(ADR_RESYNC)) begin
      rd_d[CNT_W-1:0] = resync_cnt;
    end else if (rd_addr_i == ADDR_W'(ADR_PLL)) begin
      rd_d[CNT_W-1:0] = pll_cnt;
      rd_d[CNT_W]     = lock_s;
    end else if (rd_addr_i == ADDR_W'(ADR_MEMRST)) begin
      rd_d[CNT_W-1:0] = mem_cnt;
    end else begin
      for (int i = 0; i < NUM_LANES; i++) begin
        if (rd_addr_i == ADDR_W'(ADR_LANE0 + i)) rd_d[CNT_W-1:0] = lane_cnt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

  a_r3_resync_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_all_s && !sync_all_q && !clr_resync && resync_cnt != MAX_V) |=> (resync_cnt != '0));
  a_r4_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !lock_s && !clr_pll && pll_cnt != MAX_V) |=> (pll_cnt != '0));
  a_r5_memrst_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (memrst_q && !memrst_s && !clr_mem && mem_cnt != MAX_V) |=> (mem_cnt != '0));
  a_r3_single_core_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_all_s && !clr_resync) |=> $stable(resync_cnt));
endmodule

// File: tb/link_health_mon_bench.sv
module link_health_mon_bench;
  logic        clk;
  logic        rst_ni;
  logic [1:0]  sysref_seen;
  logic [1:0]  link_sync;
  logic [15:0] lane_err;
  logic        pll_lock;
  logic        mem_rst;
  logic        rd_en;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;

  int n_checks;
  int n_fail;
  bit done;

  link_health_mon u_link_health_mon (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .sysref_seen_i (sysref_seen),
    .link_sync_i   (link_sync),
    .lane_err_i    (lane_err),
    .pll_lock_i    (pll_lock),
    .mem_rst_i     (mem_rst),
    .rd_en_i       (rd_en),
    .rd_addr_i     (rd_addr),
    .rd_data_o     (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int sat16(input int n);
    return (n > 65535) ? 65535 : n;
  endfunction

  function automatic logic [31:0] status_exp(input logic [1:0] sr, input logic [1:0] sy,
                                             input logic lk, input logic clean);
    return {28'd0, clean, lk, sr & sy};
  endfunction

  function automatic logic [31:0] pll_exp(input logic lk, input int n);
    return {15'd0, lk, 16'(sat16(n))};
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en   = 1'b0;
    d       = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int          cnt [16];
    int          falls;
    logic        prev_lock;
    void'($urandom(32'h5eed1234));
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_ni = 1'b0; sysref_seen = '0; link_sync = '0; lane_err = '0;
    pll_lock = 1'b0; mem_rst = 1'b0; rd_en = 1'b0; rd_addr = '0;
    idle(5);
    rst_ni = 1'b1;
    idle(5);

    // R6: reset state
    rd(5'h00, d); check(d, 32'h8, "R6 reset status");
    rd(5'h01, d); check(d, 0, "R6 reset resync");
    rd(5'h02, d); check(d, 0, "R6 reset pll");
    rd(5'h03, d); check(d, 0, "R6 reset memrst");
    for (int i = 0; i < 16; i++) begin
      rd(5'(16 + i), d); check(d, 0, "R2 reset lane");
    end

    // R1: link status per core
    @(negedge clk); sysref_seen = 2'b01; link_sync = 2'b11;
    idle(4);
    rd(5'h00, d); check(d, status_exp(2'b01, 2'b11, 1'b0, 1'b1), "R1 core0 up");
    rd(5'h00, d); check(d, status_exp(2'b01, 2'b11, 1'b0, 1'b1), "R1 status live after read");
    @(negedge clk); sysref_seen = 2'b11;
    idle(4);
    rd(5'h00, d); check(d, status_exp(2'b11, 2'b11, 1'b0, 1'b1), "R1 both up");
    @(negedge clk); link_sync = 2'b01;
    idle(4);
    rd(5'h00, d); check(d, status_exp(2'b11, 2'b01, 1'b0, 1'b1), "R1 core1 sync lost");

    // R3: resync on AND rising edge
    @(negedge clk); link_sync = 2'b11;
    idle(4);
    rd(5'h01, d); check(d, 2, "R3 two rises");
    rd(5'h01, d); check(d, 0, "R6 resync cleared");
    @(negedge clk); link_sync = 2'b00;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); link_sync = 2'b01;
      idle(2);
      @(negedge clk); link_sync = 2'b00;
      idle(2);
    end
    idle(4);
    rd(5'h01, d); check(d, 0, "R3 single core toggles ignored");
    @(negedge clk); link_sync = 2'b11;
    idle(4);
    rd(5'h01, d); check(d, 1, "R3 rise after both low");

    // R4: lock and single cycle drop
    @(negedge clk); pll_lock = 1'b1;
    idle(4);
    rd(5'h02, d); check(d, pll_exp(1'b1, 0), "R4 locked no loss");
    @(negedge clk); pll_lock = 1'b0;
    @(negedge clk); pll_lock = 1'b1;
    idle(4);
    rd(5'h02, d); check(d, pll_exp(1'b1, 1), "R4 single cycle drop");
    rd(5'h02, d); check(d, pll_exp(1'b1, 0), "R6 pll count cleared lock kept");
    rd(5'h00, d); check(d, status_exp(2'b11, 2'b11, 1'b1, 1'b1), "R9 lock bit in status");

    // R5: memory reset falling edges
    @(negedge clk); mem_rst = 1'b1;
    idle(3);
    @(negedge clk); mem_rst = 1'b0;
    idle(3);
    @(negedge clk); mem_rst = 1'b1;
    @(negedge clk); mem_rst = 1'b0;
    idle(4);
    rd(5'h03, d); check(d, 2, "R5 two falls");
    rd(5'h03, d); check(d, 0, "R6 memrst cleared");

    // R2/R4/R9: random sparse errors and lock drops
    for (int i = 0; i < 16; i++) cnt[i] = 0;
    falls = 0;
    prev_lock = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      lane_err = 16'($urandom & $urandom & $urandom);
      pll_lock = (($urandom % 6) != 0);
      for (int i = 0; i < 16; i++) cnt[i] += lane_err[i];
      if (prev_lock && !pll_lock) falls++;
      prev_lock = pll_lock;
    end
    @(negedge clk); lane_err = '0; pll_lock = 1'b1;
    idle(5);
    rd(5'h00, d); check(d, status_exp(2'b11, 2'b11, 1'b1, 1'b0), "R9 summary low with errors");
    for (int i = 0; i < 16; i++) begin
      rd(5'(16 + i), d); check(d, 32'(sat16(cnt[i])), "R2 random lane count");
    end
    rd(5'h02, d); check(d, pll_exp(1'b1, falls), "R4 random lock drops");
    rd(5'h00, d); check(d, status_exp(2'b11, 2'b11, 1'b1, 1'b1), "R9 summary high when clean");

    // R7: event in the cycle of the clearing read
    @(negedge clk); lane_err[5] = 1'b1;
    @(negedge clk); lane_err[5] = 1'b0;
    rd(5'h15, d); check(d, 0, "R7 read returns old value");
    rd(5'h15, d); check(d, 1, "R7 event kept after clear");

    // R8: saturation
    @(negedge clk); lane_err[3] = 1'b1;
    idle(65540);
    @(negedge clk); lane_err[3] = 1'b0;
    idle(4);
    rd(5'h13, d); check(d, 65535, "R8 saturated");
    rd(5'h13, d); check(d, 0, "R8 cleared after saturation");
    rd(5'h10, d); check(d, 0, "R10 neighbour lane untouched");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule